// File: doc/BRIEF.md
# Multi-Lane Framed Double-Rate Serializer

This block turns one wide parallel payload word into a frame that repeats without a gap. The frame goes out over several output lanes, and each lane emits two bit slots per system clock cycle. Lane 0 forwards a bit-clock waveform. That waveform is an arbitrary pattern, `T_CLK` slots long. Because `T_CLK` may be odd, the pattern's phase moves between the two slots of a word from one cycle to the next.

Lane 1 spends the first slot of every bit-clock period on a frame-marker bit. The marker is high only in the last period of the frame, so a receiver finds the frame boundary as a run of zeros followed by a one. All other slots on lanes 1 and up carry payload bits. The last `N_CRC` of those slots in each frame carry a CRC, computed with a configurable polynomial over the payload bits of that frame.

The block is parameterized by lane count, bit-clock period and pattern, periods per frame, CRC width and CRC polynomial. The payload width is derived from these parameters. Serialization to pins, the receiver and clock-domain crossing are handled elsewhere.

Top module: `ddr_frame_serializer`

## Requirements
- R1: Lane l occupies `lanes_o[2l+1:2l]`. Bit 2l+1 is the earlier slot of the cycle and bit 2l the later one. Slot s of a frame leaves in frame cycle s/2.
- R2: Lane 0 carries `CLK_PAT[T_CLK-1]` first and `CLK_PAT[0]` last, and then repeats. The cycle-0 pattern phase is 0 in every frame. With pattern 1100011 (7 slots), the lane-0 words cycle 3,0,1,3,2,0,3. With pattern 00001111 (8 slots), they cycle 0,0,3,3.
- R3: A frame lasts `T_CLK*N_FRAME/2` cycles: 49 cycles for (7, 14) and 40 cycles for (8, 10). Frames follow each other with no idle cycle.
- R4: In every bit-clock period, the first slot of lane 1 holds the marker. The marker is 1 in the last period (index `N_FRAME-1`) and 0 in all other periods.
- R5: The data slots are every slot on lanes 1 to `N_LANES-1` except the marker slots. They are ordered by slot index, and within one slot by ascending lane. The first `PAY_W` data slots carry the payload, MSB first.
- R6: The last `N_CRC` data slots carry the CRC, MSB first. The CRC starts at zero for each frame and covers only the payload bits, in data order. For each bit b: f = b ^ crc[MSB]; crc = crc<<1; if f, crc ^= `CRC_POLY`.
- R7: The payload is captured on the clock edge that produces frame cycle 0. Changes to `payload_i` after that edge have no effect on that frame.
- R8: While `rst_n` is low, `lanes_o` is 0. The first word after reset is cycle 0 of a frame.
- R9: `PAY_W = N_LANES*T_CLK*N_FRAME - T_CLK*N_FRAME - N_FRAME - N_CRC`, which is 660 for the default configuration and 544 for the (8, 10, CRC6) configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| payload_i | input | PAY_W | Payload word, captured at each frame start |
| lanes_o | output | 2*N_LANES | Two slots per lane per cycle, registered |

## Verification
In the last cycle of a frame, the final payload bits and the first CRC bits leave together. The CRC emitted in that cycle must already include the payload bits of the same cycle. The bench provokes this with payloads whose lowest bits differ, such as a lone one at the LSB. It compares every output word against a frame that it builds slot by slot from the requirements.

The bench also drives the inverted payload during each frame, which tests capture against a mid-frame change. Both the odd-period and the even-period configurations are run.

// File: rtl/ddr_frame_serializer.sv
module ddr_frame_serializer #(
  parameter int          N_LANES  = 8,
  parameter int          T_CLK    = 7,
  parameter logic [31:0] CLK_PAT  = 32'b1100011,
  parameter int          N_FRAME  = 14,
  parameter int          N_CRC    = 12,
  parameter logic [31:0] CRC_POLY = 32'h80f,
  localparam int PAY_W = N_LANES*T_CLK*N_FRAME - T_CLK*N_FRAME - N_FRAME - N_CRC
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PAY_W-1:0]       payload_i,
  output logic [2*N_LANES-1:0]   lanes_o
);
  localparam int CYC  = T_CLK*N_FRAME/2;
  localparam int CW   = $clog2(CYC);
  localparam int PHW  = $clog2(T_CLK);
  localparam int PRW  = $clog2(N_FRAME+1);
  localparam int PTW  = $clog2(PAY_W+N_CRC+1);
  localparam int PIW  = $clog2(PAY_W);
  localparam int CIW  = $clog2(N_CRC);
  localparam int WIW  = $clog2(2*N_LANES);
  localparam logic [N_CRC-1:0] POLY_V = N_CRC'(CRC_POLY);

  logic [CW-1:0]          cyc_q;
  logic [PHW-1:0]         ph_q, ph_n;
  logic [PRW-1:0]         per_q, per_n;
  logic [PTW-1:0]         ptr_q, ptr_n;
  logic [N_CRC-1:0]       crc_q, crc_n;
  logic [PAY_W-1:0]       pay_q, pay_cur;
  logic [2*N_LANES-1:0]   word;
  logic                   frame_start;

  assign frame_start = (cyc_q == '0);
  assign pay_cur     = frame_start ? payload_i : pay_q;

  always_comb begin
    int p, pr, k, p2, pr2;
    logic b, fb;
    crc_n = frame_start ? '0 : crc_q;
    k     = frame_start ? 0 : int'(ptr_q);
    word  = '0;
    b     = 1'b0;
    fb    = 1'b0;
    for (int j = 0; j < 2; j++) begin
      p  = int'(ph_q) + j;
      pr = int'(per_q);
      if (p >= T_CLK) begin
        p  = p - T_CLK;
        pr = pr + 1;
      end
      word[WIW'(1-j)] = CLK_PAT[5'(T_CLK-1-p)];
      for (int l = 1; l < N_LANES; l++) begin
        if (l == 1 && p == 0) begin
          word[WIW'(2*l+1-j)] = (pr == N_FRAME-1);
        end else begin
          if (k < PAY_W) begin
            b     = pay_cur[PIW'(PAY_W-1-k)];
            fb    = b ^ crc_n[N_CRC-1];
            crc_n = {crc_n[N_CRC-2:0], 1'b0} ^ (fb ? POLY_V : '0);
            word[WIW'(2*l+1-j)] = b;
          end else if (k < PAY_W + N_CRC) begin
            word[WIW'(2*l+1-j)] = crc_n[CIW'(N_CRC-1-(k-PAY_W))];
          end
          k = k + 1;
        end
      end
    end
    ptr_n = PTW'(k);
    p2  = int'(ph_q) + 2;
    pr2 = int'(per_q);
    if (p2 >= T_CLK) begin
      p2  = p2 - T_CLK;
      pr2 = pr2 + 1;
    end
    ph_n  = PHW'(p2);
    per_n = (int'(cyc_q) == CYC-1) ? '0 : PRW'(pr2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      ph_q    <= '0;
      per_q   <= '0;
      ptr_q   <= '0;
      crc_q   <= '0;
      pay_q   <= '0;
      lanes_o <= '0;
    end else begin
      cyc_q   <= (int'(cyc_q) == CYC-1) ? '0 : cyc_q + 1'b1;
      ph_q    <= ph_n;
      per_q   <= per_n;
      ptr_q   <= ptr_n;
      crc_q   <= crc_n;
      pay_q   <= pay_cur;
      lanes_o <= word;
    end
  end
endmodule

// File: rtl/ddr_frame_serializer_chk.sv
module ddr_frame_serializer_chk #(
  parameter int CYC = 49,
  parameter int TOT = 672,
  parameter int CW  = 6,
  parameter int PHW = 3,
  parameter int PTW = 10,
  parameter int OW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [OW-1:0]  lanes_o,
  input logic [CW-1:0]  cyc_q,
  input logic [PHW-1:0] ph_q,
  input logic [PTW-1:0] ptr_q
);
  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |=> lanes_o == '0);

  assert_frame_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cyc_q) < CYC);

  assert_phase_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == '0) |-> (ph_q == '0));

  assert_slots_filled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == '0 && ptr_q != '0) |-> (int'(ptr_q) == TOT));
endmodule

bind ddr_frame_serializer ddr_frame_serializer_chk #(
  .CYC(CYC), .TOT(PAY_W+N_CRC), .CW(CW), .PHW(PHW), .PTW(PTW), .OW(2*N_LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lanes_o(lanes_o),
  .cyc_q(cyc_q), .ph_q(ph_q), .ptr_q(ptr_q)
);

// File: tb/ddr_frame_serializer_bench.sv
`timescale 1ns/1ps
module ddr_frame_serializer_bench;
  localparam int PW_A = 8*7*14 - 7*14 - 14 - 12;
  localparam int PW_B = 8*8*10 - 8*10 - 10 - 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW_A-1:0] pay_a = '0;
  logic [PW_B-1:0] pay_b = '0;
  logic [15:0] lanes_a, lanes_b;
  logic [15:0] exp_w [0:63];
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ddr_frame_serializer u_ddr_frame_serializer (
    .clk(clk), .rst_n(rst_n), .payload_i(pay_a), .lanes_o(lanes_a));

  ddr_frame_serializer #(
    .N_LANES(8), .T_CLK(8), .CLK_PAT(32'b00001111), .N_FRAME(10),
    .N_CRC(6), .CRC_POLY(32'h2f)
  ) u_ddr_frame_serializer_even (
    .clk(clk), .rst_n(rst_n), .payload_i(pay_b), .lanes_o(lanes_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1023:0] v);
    pay_a = v[PW_A-1:0];
    pay_b = v[PW_B-1:0];
  endtask

  function automatic logic [1023:0] gen(int idx, int pw);
    logic [1023:0] v;
    logic [31:0] x;
    case (idx)
      0: v = '1;
      1: v = '0;
      2: v = {512{2'b10}};
      3: v = 1024'(1) << (pw-1);
      4: v = 1024'(1);
      default: begin
        x = 32'h1234_5679 + 32'(idx);
        for (int i = 0; i < 32; i++) begin
          x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
          v[i*32 +: 32] = x;
        end
      end
    endcase
    return v;
  endfunction

  task automatic build(int nl, int t, int nf, int nc, logic [31:0] pat,
                       logic [31:0] poly, int pw, logic [1023:0] v);
    logic bits [0:7][0:127];
    logic [31:0] crc;
    logic b, fb;
    int k;
    logic [15:0] w;
    crc = '0;
    k = 0;
    for (int s = 0; s < t*nf; s++) begin
      for (int l = 0; l < nl; l++) begin
        if (l == 0) bits[l][s] = pat[t-1-(s%t)];
        else if (l == 1 && (s%t) == 0) bits[l][s] = ((s/t) == nf-1);
        else begin
          if (k < pw) begin
            b  = v[pw-1-k];
            bits[l][s] = b;
            fb = b ^ crc[nc-1];
            crc = (crc << 1) & ((32'd1 << nc) - 1);
            if (fb) crc = crc ^ poly;
          end else begin
            bits[l][s] = crc[nc-1-(k-pw)];
          end
          k++;
        end
      end
    end
    for (int c = 0; c < t*nf/2; c++) begin
      w = '0;
      for (int l = 0; l < nl; l++) begin
        w[2*l+1] = bits[l][2*c];
        w[2*l]   = bits[l][2*c+1];
      end
      exp_w[c] = w;
    end
  endtask

  function automatic logic [1:0] clk_word(bit sel, int c);
    if (!sel) begin
      case (c % 7)
        0: return 2'd3; 1: return 2'd0; 2: return 2'd1; 3: return 2'd3;
        4: return 2'd2; 5: return 2'd0; default: return 2'd3;
      endcase
    end else begin
      case (c % 4)
        0, 1: return 2'd0;
        default: return 2'd3;
      endcase
    end
  endfunction

  task automatic run(bit sel);
    int t, nf, nc, pw, cyc;
    logic [31:0] pat, poly;
    logic [1023:0] v;
    logic [15:0] act;
    int s;
    t    = sel ? 8 : 7;
    nf   = sel ? 10 : 14;
    nc   = sel ? 6 : 12;
    pw   = sel ? PW_B : PW_A;
    pat  = sel ? 32'b00001111 : 32'b1100011;
    poly = sel ? 32'h2f : 32'h80f;
    cyc  = t*nf/2;
    rst_n = 1'b0;
    drive(gen(0, pw));
    repeat (3) @(negedge clk);
    chk("R8 reset output", 32'(sel ? lanes_b : lanes_a), 32'd0);
    rst_n = 1'b1;
    for (int f = 0; f < 7; f++) begin
      v = gen(f, pw);
      build(8, t, nf, nc, pat, poly, pw, v);
      for (int c = 0; c < cyc; c++) begin
        @(negedge clk);
        act = sel ? lanes_b : lanes_a;
        chk("R1 R2 clock lane", 32'(act[1:0]), 32'(clk_word(sel, c)));
        for (int j = 0; j < 2; j++) begin
          s = 2*c + j;
          if ((s % t) == 0)
            chk("R4 marker", 32'(act[3-j]), 32'((s/t) == nf-1));
        end
        if (f == 0 && c == 0)      chk("R8 first word", 32'(act), 32'(exp_w[c]));
        else if (c == 0)           chk("R3 back-to-back", 32'(act), 32'(exp_w[c]));
        else if (c >= cyc-2)       chk("R6 crc", 32'(act), 32'(exp_w[c]));
        else                       chk("R5 R7 data", 32'(act), 32'(exp_w[c]));
        if (c == 0) drive(~v);
        if (c == cyc-1) drive(gen(f+1, pw));
      end
    end
  endtask

  initial begin
    chk("R9 width A", 32'($bits(pay_a)), 32'd660);
    chk("R9 width B", 32'($bits(pay_b)), 32'd544);
    run(1'b0);
    run(1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule